// File: doc/BRIEF.md
# Virtual Frame Rolling Readout Timing Generator

This block paces a continuous rolling-shutter readout. It walks a programmable virtual frame, column by column and row by row, on the master clock. It tells the downstream path which positions carry real pixels, where each line's valid span lies and where a frame begins. The virtual frame is at least as large as the window of interest. Its size, and not the window's, sets the line and frame periods. Window positions that fall beyond the physical pixel array (704 columns by 512 rows) are sent as dark padding: line sync stays high there but pixel-valid does not.

Every frame ends with a tail segment. When rows are short (row period below 719 clocks), the tail is a fixed-length frame-clamp interval that leaves room for black-level clamping. Otherwise the tail is one extra row. A rolling integration reset pointer runs a programmed number of rows ahead of the readout row, so the exposure can be set in whole rows. Size writes keep the window inside the virtual frame. Every setting is applied only at a frame boundary.

Top module: `vframe_timing_gen`

## Requirements
- R1: While reset is low, sof, line_sync, pix_valid and clamp_on are 0 and rd_row is 0. The reset settings are a 16x4 virtual frame, an 8x3 window at pointer (0,0), trims 0 and lead 0. In the first cycle after reset is released, sof is 1.
- R2: Every data row lasts vf_cols + trim_a + trim_b + 19 clocks. rd_row counts 0, 1, ... up to vf_rows-1 and then holds vf_rows during the tail segment.
- R3: If the row period is below 719 clocks, the tail lasts 719 + trim_a + trim_b + 19 clocks with clamp_on high throughout. If the row period is 719 or more, the tail lasts one row period and clamp_on stays low. The frame period is therefore vf_rows x row + clamp, or (vf_rows + 1) x row.
- R4: sof is high for exactly one clock, at virtual row 0, column 0.
- R5: line_sync is high exactly when the virtual column is below the window width and the data row is below the window height.
- R6: pix_valid is high only where line_sync is high, col_ptr + column < 704 and row_ptr + row < 512. All other window positions are dark padding.
- R7: A window write that exceeds the stored virtual frame in a dimension enlarges the virtual frame in that dimension to the window size.
- R8: A virtual-frame write shrinks the stored window in any dimension where the window is larger. A size of 0 is stored as 1. When both writes happen in the same cycle, the window takes the written value and the frame takes the larger of the two written values.
- R9: Sizes, trims, pointers and lead count written during a frame leave that frame unchanged and take effect from the next sof.
- R10: int_rst_row equals (rd_row + L) mod vf_rows, where L is the lead count limited to at most vf_rows-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| win_we | input | 1 | Window size write strobe |
| win_cols_in | input | 14 | Window width to write |
| win_rows_in | input | 10 | Window height to write |
| vf_we | input | 1 | Virtual frame size write strobe |
| vf_cols_in | input | 14 | Virtual frame width to write |
| vf_rows_in | input | 10 | Virtual frame height to write |
| col_ptr | input | 10 | Physical column of window column 0 |
| row_ptr | input | 10 | Physical row of window row 0 |
| trim_a | input | 8 | First internal line timing trim, in clocks |
| trim_b | input | 8 | Second internal line timing trim, in clocks |
| lead_rows | input | 10 | Integration lead in rows |
| sof | output | 1 | Start-of-frame pulse |
| line_sync | output | 1 | High across the window span of a row |
| pix_valid | output | 1 | Current position is a real array pixel |
| clamp_on | output | 1 | Frame-clamp tail in progress |
| rd_row | output | 10 | Current readout row of the virtual frame |
| int_rst_row | output | 10 | Row whose integration is being reset |

## Verification
On every cycle, the embedded properties check that the stored window stays inside the stored frame and that a stored frame dimension is never zero. They also check that the column counter never passes the current segment length, that rows advance by one at each row end, and that active settings move only at a frame end. Finally, they check that sof never lasts two clocks, that pix_valid implies line_sync, that the clamp tail always hands over to sof, and that the reset pointer stays below the frame depth. The exact frame periods at and around the 719-clock limit, the growing and shrinking of sizes after writes, the dark padding at the array edge and the deferral of mid-frame writes depend on sequences of writes and whole frames. Only the bench scenarios, which compare against a cycle model and count periods and valid cycles, show them.

// File: rtl/vft_pkg.sv
// Shared types for the virtual-frame timing generator.
package vft_pkg;
    // Which part of the frame the raster is in.
    typedef enum logic {
        SEG_ROWS = 1'b0,
        SEG_TAIL = 1'b1
    } seg_e;
endpackage

// File: rtl/vft_shadow_regs.sv
// Holds the written window and virtual-frame sizes and keeps the window
// inside the frame. Assumes the default window fits the default frame.
module vft_shadow_regs #(
    parameter int COL_W        = 14,
    parameter int ROW_W        = 10,
    parameter int DEF_VF_COLS  = 16,
    parameter int DEF_VF_ROWS  = 4,
    parameter int DEF_WIN_COLS = 8,
    parameter int DEF_WIN_ROWS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_we,
    input  logic [COL_W-1:0] win_cols_in,
    input  logic [ROW_W-1:0] win_rows_in,
    input  logic             vf_we,
    input  logic [COL_W-1:0] vf_cols_in,
    input  logic [ROW_W-1:0] vf_rows_in,
    output logic [COL_W-1:0] sh_vf_cols,
    output logic [ROW_W-1:0] sh_vf_rows,
    output logic [COL_W-1:0] sh_win_cols,
    output logic [ROW_W-1:0] sh_win_rows
);
    logic [COL_W-1:0] vfc_req, vfc_nx, winc_nx;
    logic [ROW_W-1:0] vfr_req, vfr_nx, winr_nx;

    // Next sizes: a frame write clips the window, a window write widens the frame.
    always_comb begin
        vfc_req = (vf_cols_in == '0) ? COL_W'(1) : vf_cols_in;
        vfr_req = (vf_rows_in == '0) ? ROW_W'(1) : vf_rows_in;
        vfc_nx  = sh_vf_cols;
        vfr_nx  = sh_vf_rows;
        winc_nx = sh_win_cols;
        winr_nx = sh_win_rows;
        if (vf_we) begin
            vfc_nx  = vfc_req;
            vfr_nx  = vfr_req;
            winc_nx = (sh_win_cols > vfc_req) ? vfc_req : sh_win_cols;
            winr_nx = (sh_win_rows > vfr_req) ? vfr_req : sh_win_rows;
        end
        if (win_we) begin
            winc_nx = win_cols_in;
            winr_nx = win_rows_in;
            if (win_cols_in > vfc_nx) vfc_nx = win_cols_in;
            if (win_rows_in > vfr_nx) vfr_nx = win_rows_in;
        end
    end

    // Size storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_vf_cols  <= COL_W'(DEF_VF_COLS);
            sh_vf_rows  <= ROW_W'(DEF_VF_ROWS);
            sh_win_cols <= COL_W'(DEF_WIN_COLS);
            sh_win_rows <= ROW_W'(DEF_WIN_ROWS);
        end else begin
            sh_vf_cols  <= vfc_nx;
            sh_vf_rows  <= vfr_nx;
            sh_win_cols <= winc_nx;
            sh_win_rows <= winr_nx;
        end
    end

    // R7 / R8: stored window never exceeds stored frame.
    assert_win_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_win_cols <= sh_vf_cols) && (sh_win_rows <= sh_vf_rows));
    // R8: a stored frame dimension is never zero.
    assert_frame_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_vf_cols != '0) && (sh_vf_rows != '0));
endmodule

// File: rtl/vft_raster_counter.sv
// Column/row raster over the virtual frame plus its tail segment. Latches
// all settings at the frame end so a frame runs on one consistent set.
// Assumes TRIM_W is at most COL_W-2 so row lengths fit RT_W bits.
module vft_raster_counter
    import vft_pkg::*;
#(
    parameter int COL_W        = 14,
    parameter int ROW_W        = 10,
    parameter int TRIM_W       = 8,
    parameter int PTR_W        = 10,
    parameter int RT_W         = 16,
    parameter int CLAMP_LIMIT  = 719,
    parameter int ROW_OVERHEAD = 19,
    parameter int DEF_VF_COLS  = 16,
    parameter int DEF_VF_ROWS  = 4,
    parameter int DEF_WIN_COLS = 8,
    parameter int DEF_WIN_ROWS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  sh_vf_cols,
    input  logic [ROW_W-1:0]  sh_vf_rows,
    input  logic [COL_W-1:0]  sh_win_cols,
    input  logic [ROW_W-1:0]  sh_win_rows,
    input  logic [TRIM_W-1:0] trim_a,
    input  logic [TRIM_W-1:0] trim_b,
    input  logic [PTR_W-1:0]  col_ptr,
    input  logic [PTR_W-1:0]  row_ptr,
    input  logic [ROW_W-1:0]  lead_rows,
    output logic              started,
    output logic [RT_W-1:0]   col,
    output logic [ROW_W-1:0]  row,
    output logic              in_tail,
    output logic              short_rows,
    output logic [ROW_W-1:0]  act_vf_rows,
    output logic [COL_W-1:0]  act_win_cols,
    output logic [ROW_W-1:0]  act_win_rows,
    output logic [PTR_W-1:0]  act_col_ptr,
    output logic [PTR_W-1:0]  act_row_ptr,
    output logic [ROW_W-1:0]  act_lead
);
    logic [COL_W-1:0]  act_vf_cols;
    logic [TRIM_W-1:0] act_trim_a, act_trim_b;
    logic [RT_W-1:0]   row_len, tail_len, cur_len;
    logic              row_end, frame_end;
    seg_e              seg;

    // Segment lengths from the active settings.
    always_comb begin
        row_len    = RT_W'(act_vf_cols) + RT_W'(act_trim_a) + RT_W'(act_trim_b)
                   + RT_W'(ROW_OVERHEAD);
        short_rows = row_len < RT_W'(CLAMP_LIMIT);
        tail_len   = short_rows ? (RT_W'(CLAMP_LIMIT) + RT_W'(act_trim_a)
                                   + RT_W'(act_trim_b) + RT_W'(ROW_OVERHEAD))
                                : row_len;
        seg        = (row == act_vf_rows) ? SEG_TAIL : SEG_ROWS;
        in_tail    = (seg == SEG_TAIL);
        cur_len    = in_tail ? tail_len : row_len;
        row_end    = (col == cur_len - RT_W'(1));
        frame_end  = started && in_tail && row_end;
    end

    // Run flag: the raster starts one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // Column and row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (started) begin
            if (row_end) begin
                col <= '0;
                row <= in_tail ? '0 : row + ROW_W'(1);
            end else begin
                col <= col + RT_W'(1);
            end
        end
    end

    // Frame-boundary latch of every setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_vf_cols  <= COL_W'(DEF_VF_COLS);
            act_vf_rows  <= ROW_W'(DEF_VF_ROWS);
            act_win_cols <= COL_W'(DEF_WIN_COLS);
            act_win_rows <= ROW_W'(DEF_WIN_ROWS);
            act_trim_a   <= '0;
            act_trim_b   <= '0;
            act_col_ptr  <= '0;
            act_row_ptr  <= '0;
            act_lead     <= '0;
        end else if (frame_end) begin
            act_vf_cols  <= sh_vf_cols;
            act_vf_rows  <= sh_vf_rows;
            act_win_cols <= sh_win_cols;
            act_win_rows <= sh_win_rows;
            act_trim_a   <= trim_a;
            act_trim_b   <= trim_b;
            act_col_ptr  <= col_ptr;
            act_row_ptr  <= row_ptr;
            act_lead     <= lead_rows;
        end
    end

    // R2: column never runs past the current segment.
    assert_col_in_segment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col < cur_len);
    // R2: a data row end moves to the next row at column 0.
    assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && row_end && !in_tail) |=> (col == '0) && (row == $past(row) + ROW_W'(1)));
    // R9: active settings move only at a frame end.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(act_vf_cols) && $stable(act_vf_rows)
                       && $stable(act_win_cols) && $stable(act_trim_a) && $stable(act_lead));
endmodule

// File: rtl/vft_pixel_qualify.sv
// Turns raster position into sof, line_sync, pix_valid and clamp_on.
// Assumes PTR_W is at most RT_W and the window lies inside the frame.
module vft_pixel_qualify #(
    parameter int COL_W      = 14,
    parameter int ROW_W      = 10,
    parameter int PTR_W      = 10,
    parameter int RT_W       = 16,
    parameter int ARRAY_COLS = 704,
    parameter int ARRAY_ROWS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             started,
    input  logic [RT_W-1:0]  col,
    input  logic [ROW_W-1:0] row,
    input  logic             in_tail,
    input  logic             short_rows,
    input  logic [COL_W-1:0] act_win_cols,
    input  logic [ROW_W-1:0] act_win_rows,
    input  logic [PTR_W-1:0] act_col_ptr,
    input  logic [PTR_W-1:0] act_row_ptr,
    output logic             sof,
    output logic             line_sync,
    output logic             pix_valid,
    output logic             clamp_on
);
    localparam int PC_W = RT_W + 1;
    localparam int PR_W = ((ROW_W > PTR_W) ? ROW_W : PTR_W) + 1;

    logic in_win, phys_col_ok, phys_row_ok;

    // Window span and physical-array bounds for the current position.
    always_comb begin
        in_win      = started && !in_tail && (col < RT_W'(act_win_cols))
                      && (row < act_win_rows);
        phys_col_ok = (PC_W'(act_col_ptr) + PC_W'(col)) < PC_W'(ARRAY_COLS);
        phys_row_ok = (PR_W'(act_row_ptr) + PR_W'(row)) < PR_W'(ARRAY_ROWS);
        line_sync   = in_win;
        pix_valid   = in_win && phys_col_ok && phys_row_ok;
        sof         = started && (row == '0) && (col == '0);
        clamp_on    = started && in_tail && short_rows;
    end

    // R4: sof never lasts two clocks.
    assert_sof_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);
    // R6: a valid pixel always lies inside the line span.
    assert_pix_in_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> line_sync);
    // R3: the clamp tail ends exactly where the next frame starts.
    assert_clamp_to_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_on) |-> sof);
endmodule

// File: rtl/vft_integ_ptr.sv
// Rolling integration reset row: readout row plus a lead, wrapped by the
// frame depth. Assumes row never exceeds vf_rows and vf_rows is nonzero.
module vft_integ_ptr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] act_vf_rows,
    input  logic [ROW_W-1:0] act_lead,
    output logic [ROW_W-1:0] int_rst_row
);
    logic [ROW_W-1:0] lead_eff;
    logic [ROW_W:0]   sum;

    // Limit the lead to one frame, then wrap with a single subtraction.
    always_comb begin
        lead_eff    = (act_lead < act_vf_rows) ? act_lead : act_vf_rows - ROW_W'(1);
        sum         = {1'b0, row} + {1'b0, lead_eff};
        int_rst_row = (sum >= {1'b0, act_vf_rows}) ? ROW_W'(sum - {1'b0, act_vf_rows})
                                                   : ROW_W'(sum);
    end

    // R10: the reset pointer always addresses a row of the frame.
    assert_ptr_below_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_row < act_vf_rows);
endmodule

// File: rtl/vframe_timing_gen.sv
// Top of the virtual-frame rolling timing generator: size registers with
// containment, frame-latched raster, pixel qualification, reset pointer.
// Assumes one pixel per master clock.
module vframe_timing_gen #(
    parameter int COL_W        = 14,
    parameter int ROW_W        = 10,
    parameter int TRIM_W       = 8,
    parameter int PTR_W        = 10,
    parameter int ARRAY_COLS   = 704,
    parameter int ARRAY_ROWS   = 512,
    parameter int CLAMP_LIMIT  = 719,
    parameter int ROW_OVERHEAD = 19,
    parameter int DEF_VF_COLS  = 16,
    parameter int DEF_VF_ROWS  = 4,
    parameter int DEF_WIN_COLS = 8,
    parameter int DEF_WIN_ROWS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [COL_W-1:0]  win_cols_in,
    input  logic [ROW_W-1:0]  win_rows_in,
    input  logic              vf_we,
    input  logic [COL_W-1:0]  vf_cols_in,
    input  logic [ROW_W-1:0]  vf_rows_in,
    input  logic [PTR_W-1:0]  col_ptr,
    input  logic [PTR_W-1:0]  row_ptr,
    input  logic [TRIM_W-1:0] trim_a,
    input  logic [TRIM_W-1:0] trim_b,
    input  logic [ROW_W-1:0]  lead_rows,
    output logic              sof,
    output logic              line_sync,
    output logic              pix_valid,
    output logic              clamp_on,
    output logic [ROW_W-1:0]  rd_row,
    output logic [ROW_W-1:0]  int_rst_row
);
    localparam int RT_W = COL_W + 2;

    logic [COL_W-1:0] sh_vf_cols, sh_win_cols, act_win_cols;
    logic [ROW_W-1:0] sh_vf_rows, sh_win_rows, act_vf_rows, act_win_rows, act_lead, row;
    logic [PTR_W-1:0] act_col_ptr, act_row_ptr;
    logic [RT_W-1:0]  col;
    logic             started, in_tail, short_rows;

    vft_shadow_regs #(
        .COL_W(COL_W), .ROW_W(ROW_W),
        .DEF_VF_COLS(DEF_VF_COLS), .DEF_VF_ROWS(DEF_VF_ROWS),
        .DEF_WIN_COLS(DEF_WIN_COLS), .DEF_WIN_ROWS(DEF_WIN_ROWS)
    ) shadow_i (
        .clk(clk), .rst_n(rst_n),
        .win_we(win_we), .win_cols_in(win_cols_in), .win_rows_in(win_rows_in),
        .vf_we(vf_we), .vf_cols_in(vf_cols_in), .vf_rows_in(vf_rows_in),
        .sh_vf_cols(sh_vf_cols), .sh_vf_rows(sh_vf_rows),
        .sh_win_cols(sh_win_cols), .sh_win_rows(sh_win_rows)
    );

    vft_raster_counter #(
        .COL_W(COL_W), .ROW_W(ROW_W), .TRIM_W(TRIM_W), .PTR_W(PTR_W), .RT_W(RT_W),
        .CLAMP_LIMIT(CLAMP_LIMIT), .ROW_OVERHEAD(ROW_OVERHEAD),
        .DEF_VF_COLS(DEF_VF_COLS), .DEF_VF_ROWS(DEF_VF_ROWS),
        .DEF_WIN_COLS(DEF_WIN_COLS), .DEF_WIN_ROWS(DEF_WIN_ROWS)
    ) raster_i (
        .clk(clk), .rst_n(rst_n),
        .sh_vf_cols(sh_vf_cols), .sh_vf_rows(sh_vf_rows),
        .sh_win_cols(sh_win_cols), .sh_win_rows(sh_win_rows),
        .trim_a(trim_a), .trim_b(trim_b), .col_ptr(col_ptr), .row_ptr(row_ptr),
        .lead_rows(lead_rows),
        .started(started), .col(col), .row(row), .in_tail(in_tail),
        .short_rows(short_rows), .act_vf_rows(act_vf_rows),
        .act_win_cols(act_win_cols), .act_win_rows(act_win_rows),
        .act_col_ptr(act_col_ptr), .act_row_ptr(act_row_ptr), .act_lead(act_lead)
    );

    vft_pixel_qualify #(
        .COL_W(COL_W), .ROW_W(ROW_W), .PTR_W(PTR_W), .RT_W(RT_W),
        .ARRAY_COLS(ARRAY_COLS), .ARRAY_ROWS(ARRAY_ROWS)
    ) qualify_i (
        .clk(clk), .rst_n(rst_n), .started(started), .col(col), .row(row),
        .in_tail(in_tail), .short_rows(short_rows),
        .act_win_cols(act_win_cols), .act_win_rows(act_win_rows),
        .act_col_ptr(act_col_ptr), .act_row_ptr(act_row_ptr),
        .sof(sof), .line_sync(line_sync), .pix_valid(pix_valid), .clamp_on(clamp_on)
    );

    vft_integ_ptr #(
        .ROW_W(ROW_W)
    ) integ_i (
        .clk(clk), .rst_n(rst_n), .row(row), .act_vf_rows(act_vf_rows),
        .act_lead(act_lead), .int_rst_row(int_rst_row)
    );

    assign rd_row = row;
endmodule

// File: tb/vframe_timing_gen_tb.sv
// Bench: behavioural cycle model compared on every clock, plus frame-level
// scenario checks of periods, line and pixel counts.
module vframe_timing_gen_tb_top;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_we = 1'b0, vf_we = 1'b0;
    logic [13:0] win_cols_in = '0, vf_cols_in = '0;
    logic [9:0]  win_rows_in = '0, vf_rows_in = '0;
    logic [9:0]  col_ptr = '0, row_ptr = '0, lead_rows = '0;
    logic [7:0]  trim_a = '0, trim_b = '0;
    logic        sof, line_sync, pix_valid, clamp_on;
    logic [9:0]  rd_row, int_rst_row;

    int total = 0, bad = 0, cyc = 0;
    bit cmp_on = 0;

    vframe_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_cols_in(win_cols_in),
        .win_rows_in(win_rows_in), .vf_we(vf_we), .vf_cols_in(vf_cols_in),
        .vf_rows_in(vf_rows_in), .col_ptr(col_ptr), .row_ptr(row_ptr),
        .trim_a(trim_a), .trim_b(trim_b), .lead_rows(lead_rows),
        .sof(sof), .line_sync(line_sync), .pix_valid(pix_valid), .clamp_on(clamp_on),
        .rd_row(rd_row), .int_rst_row(int_rst_row)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model state.
    int m_row = 0, m_col = 0;
    bit m_st = 0;
    int a_vfc = 16, a_vfr = 4, a_wc = 8, a_wr = 3, a_ta = 0, a_tb = 0, a_cp = 0, a_rp = 0, a_ld = 0;
    int s_vfc = 16, s_vfr = 4, s_wc = 8, s_wr = 3;

    // Model advance on each clock edge.
    always @(posedge clk) begin
        int rl, tl, cl, rq_c, rq_r;
        bit fe;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_row = 0; m_col = 0;
            a_vfc = 16; a_vfr = 4; a_wc = 8; a_wr = 3;
            a_ta = 0; a_tb = 0; a_cp = 0; a_rp = 0; a_ld = 0;
            s_vfc = 16; s_vfr = 4; s_wc = 8; s_wr = 3;
        end else begin
            rl = a_vfc + a_ta + a_tb + 19;
            tl = (rl < 719) ? (719 + a_ta + a_tb + 19) : rl;
            cl = (m_row == a_vfr) ? tl : rl;
            fe = m_st && (m_row == a_vfr) && (m_col == cl - 1);
            if (m_st) begin
                if (m_col == cl - 1) begin
                    m_col = 0;
                    m_row = (m_row == a_vfr) ? 0 : m_row + 1;
                end else m_col++;
            end
            if (fe) begin
                a_vfc = s_vfc; a_vfr = s_vfr; a_wc = s_wc; a_wr = s_wr;
                a_ta = int'(trim_a); a_tb = int'(trim_b);
                a_cp = int'(col_ptr); a_rp = int'(row_ptr); a_ld = int'(lead_rows);
            end
            if (vf_we) begin
                rq_c = (vf_cols_in == 0) ? 1 : int'(vf_cols_in);
                rq_r = (vf_rows_in == 0) ? 1 : int'(vf_rows_in);
                s_vfc = rq_c; s_vfr = rq_r;
                if (s_wc > rq_c) s_wc = rq_c;
                if (s_wr > rq_r) s_wr = rq_r;
            end
            if (win_we) begin
                s_wc = int'(win_cols_in); s_wr = int'(win_rows_in);
                if (s_wc > s_vfc) s_vfc = s_wc;
                if (s_wr > s_vfr) s_vfr = s_wr;
            end
            m_st = 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        bit e_sof, e_line, e_pix, e_clamp;
        int lead, e_int;
        if (cmp_on) begin
            e_sof   = m_st && m_row == 0 && m_col == 0;
            e_line  = m_st && m_row < a_vfr && m_row < a_wr && m_col < a_wc;
            e_pix   = e_line && (a_cp + m_col < 704) && (a_rp + m_row < 512);
            e_clamp = m_st && m_row == a_vfr && (a_vfc + a_ta + a_tb + 19) < 719;
            lead    = (a_ld < a_vfr) ? a_ld : a_vfr - 1;
            e_int   = (m_row + lead) % a_vfr;
            check(sof === e_sof, "R4 sof", int'(sof), int'(e_sof));
            check(line_sync === e_line, "R5 line_sync", int'(line_sync), int'(e_line));
            check(pix_valid === e_pix, "R6 pix_valid", int'(pix_valid), int'(e_pix));
            check(clamp_on === e_clamp, "R3 clamp_on", int'(clamp_on), int'(e_clamp));
            check(rd_row === 10'(m_row), "R2 rd_row", int'(rd_row), m_row);
            check(int_rst_row === 10'(e_int), "R10 int_rst_row", int'(int_rst_row), e_int);
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc >= WD_LIMIT) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_sof();
        do @(negedge clk); while (sof !== 1'b1);
    endtask

    // Called at a negedge with sof high; returns at the next sof.
    task automatic measure_frame(output int per, output int lines, output int pix, output int clamps);
        per = 0; lines = 0; pix = 0; clamps = 0;
        do begin
            if (line_sync === 1'b1) lines++;
            if (pix_valid === 1'b1) pix++;
            if (clamp_on === 1'b1) clamps++;
            per++;
            @(negedge clk);
        end while (sof !== 1'b1);
    endtask

    task automatic wr_vf(input int c, input int r);
        @(negedge clk);
        vf_we = 1'b1; vf_cols_in = 14'(c); vf_rows_in = 10'(r);
        @(negedge clk);
        vf_we = 1'b0;
    endtask

    task automatic wr_win(input int c, input int r);
        @(negedge clk);
        win_we = 1'b1; win_cols_in = 14'(c); win_rows_in = 10'(r);
        @(negedge clk);
        win_we = 1'b0;
    endtask

    initial begin
        int per, lines, pix, clamps, t0;
        repeat (2) @(negedge clk);
        cmp_on = 1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(sof === 1'b0 && line_sync === 1'b0 && pix_valid === 1'b0 && clamp_on === 1'b0,
              "R1 outputs in reset", int'({sof, line_sync, pix_valid, clamp_on}), 0);
        check(rd_row === '0, "R1 rd_row in reset", int'(rd_row), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sof === 1'b1, "R1 sof after release", int'(sof), 1);

        // R1/R3: default frame 16x4, row 35, clamp 738
        measure_frame(per, lines, pix, clamps);
        check(per == 878, "R1 R3 default period", per, 878);
        check(lines == 24, "R5 default lines", lines, 24);
        check(clamps == 738, "R3 default clamp", clamps, 738);

        // R9: mid-frame writes do not disturb the running frame
        t0 = cyc;
        trim_a = 8'd3; trim_b = 8'd5; lead_rows = 10'd2;
        wr_vf(20, 6);
        wait_sof();
        check(cyc - t0 == 878, "R9 frame unchanged", cyc - t0, 878);
        // R2/R3: row 47, clamp 746
        measure_frame(per, lines, pix, clamps);
        check(per == 1028, "R2 R3 trimmed period", per, 1028);
        check(clamps == 746, "R3 trimmed clamp", clamps, 746);

        // R3 boundary: row exactly 719, tail is one row, no clamp; R8 shrinks rows
        trim_a = '0; trim_b = '0;
        wr_vf(700, 2);
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(per == 2157, "R3 row at limit period", per, 2157);
        check(clamps == 0, "R3 no clamp at limit", clamps, 0);
        check(lines == 16, "R8 window rows shrunk", lines, 16);

        // R3 just below the limit: row 718 plus clamp 738
        wr_vf(699, 2);
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(per == 2174, "R3 row below limit period", per, 2174);
        check(clamps == 738, "R3 clamp below limit", clamps, 738);

        // R7: window 30x5 grows frame rows to 5
        wr_win(30, 5);
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(per == 4328, "R7 grown frame period", per, 4328);
        check(lines == 150, "R7 grown window lines", lines, 150);

        // R6: window near the array corner, 14 cols x 3 rows real
        col_ptr = 10'd690; row_ptr = 10'd509;
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(lines == 150, "R6 line span kept", lines, 150);
        check(pix == 42, "R6 dark padding", pix, 42);

        // R10: lead 9 limited to 5 in a 6-row frame
        lead_rows = 10'd9; col_ptr = '0; row_ptr = '0;
        wr_vf(40, 6);
        wait_sof();
        check(int_rst_row === 10'd5, "R10 pointer at row 0", int'(int_rst_row), 5);
        do @(negedge clk); while (rd_row !== 10'd3);
        check(int_rst_row === 10'd2, "R10 pointer wraps", int'(int_rst_row), 2);
        do @(negedge clk); while (rd_row !== 10'd6);
        check(int_rst_row === 10'd5, "R10 pointer in tail", int'(int_rst_row), 5);

        // R8/R7: simultaneous writes, frame 12x3, row 31
        @(negedge clk);
        vf_we = 1'b1; vf_cols_in = 14'd10; vf_rows_in = 10'd2;
        win_we = 1'b1; win_cols_in = 14'd12; win_rows_in = 10'd3;
        @(negedge clk);
        vf_we = 1'b0; win_we = 1'b0;
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(per == 831, "R8 R7 joint write period", per, 831);
        check(lines == 36, "R8 R7 joint write lines", lines, 36);

        // R8: zero size stored as 1, window clipped to 1x1
        wr_vf(0, 0);
        wait_sof();
        measure_frame(per, lines, pix, clamps);
        check(per == 758, "R8 zero size period", per, 758);
        check(lines == 1, "R8 zero size lines", lines, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule